// File: doc/BRIEF.md
# Redundant Clock Failure Switchover Controller

This block watches two redundant reference clocks from a faster, free-running sampling clock. Each reference is brought into the sampling domain through a synchronizer, and its transitions are detected there. An idle counter declares the reference stuck when no transition arrives for `TIMEOUT` sampling cycles. Set `TIMEOUT` to one nominal reference period plus some margin. A stuck reference raises its bad flag, and the flag stays up until an alarm clear, even if the clock comes back.

The block keeps a one-bit selection that drives an external clock mux and also serves as the selected-clock status. Suppose the selected reference goes bad while the other one is healthy. The selection then moves to the healthy one. A failure on the reference that is not selected only raises that reference's flag. If both references are bad, the selection stays where it is. When the manual override is high, the select pin drives the selection directly and the flags keep updating.

An alarm clear and a master reset both load the selection from the select pin. The master reset also restarts every detector.

Top module: `clkFailSwitch`

## Requirements
- R1: A reference that stays at a constant level, high or low, raises its bad flag. The flag rises no earlier than `TIMEOUT` and no later than `TIMEOUT`+5 sampling cycles after the reference's last transition.
- R2: A reference that keeps toggling never raises its flag, provided every gap between transitions is shorter than `TIMEOUT` sampling cycles. This includes a brief pause.
- R3: Once raised, a bad flag stays high until an alarm clear or a master reset, even after the reference starts toggling again.
- R4: `alarmClr` is a one-cycle, synchronous clear. At the next sampling edge it clears both flags. With the override low, that same edge loads the selection from `selPin`.
- R5: With the override low, the selection flips to the other reference one cycle after two conditions hold together: the selected reference's flag is high and the other reference's flag is low.
- R6: A failure of the reference that is not selected raises only that reference's flag and leaves the selection unchanged.
- R7: While both flags are high and the override is low, the selection holds its value.
- R8: While `manOverride` is high, the selection takes the value of `selPin` at every sampling edge, whatever the flags show. The flags keep tracking failures.
- R9: `masterRst` is synchronous and active high. It clears both flags and restarts both detectors. It also loads the selection from `selPin`.
- R10: `clkSelected` is 0 when reference 0 is selected and 1 when reference 1 is selected. `badFlag0` belongs to `refClk0` and `badFlag1` belongs to `refClk1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sampClk | input | 1 | Free-running sampling clock, faster than either reference |
| masterRst | input | 1 | Synchronous active-high master reset |
| refClk0 | input | 1 | Reference clock 0, treated as asynchronous data |
| refClk1 | input | 1 | Reference clock 1, treated as asynchronous data |
| alarmClr | input | 1 | Synchronous clear of both bad flags |
| manOverride | input | 1 | High: the selection follows selPin |
| selPin | input | 1 | Requested reference (0 or 1) |
| badFlag0 | output | 1 | Latched failure flag of reference 0 |
| badFlag1 | output | 1 | Latched failure flag of reference 1 |
| clkSelected | output | 1 | Selected reference; also the external mux select |

## Verification
The bench stops each reference at a high level and at a low level.

- A detector that watched only one polarity would miss one of these cases.
- A pause shorter than the timeout must leave the flag low. A timeout that is too short would raise the flag on this pause.
- After a failure, the reference restarts while its flag is still latched. A flag that tracked the live status would drop here.
- A failure of the reference that is not selected must not move the selection, and neither must a state where both references are bad. A design that switched on any flag would flip the selection away, or toggle it back and forth.
- Under override the selection must stay on a reference that is flagged bad. The bench also checks that an alarm clear, and a master reset, each load the selection from `selPin`.

// File: rtl/clkswPkg.sv
package clkswPkg;
  localparam int NUM_REF = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_REF-1:0] setBad;   // detector timeouts to latch
    logic               clrBad;   // alarm clear of all flags
    logic               selLoad;  // write selection register
    logic               selNext;  // value written when selLoad
  } swStrobe_t;
endpackage

// File: rtl/clkswMonitor.sv
module clkswMonitor #(
  parameter int TIMEOUT     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic sampClk,
  input  logic masterRst,
  input  logic rawClk,
  output logic stuck
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

  // synchronizer stages followed by one history stage
  logic [SYNC_STAGES:0] shiftQ;
  logic [CNT_W-1:0]     idleCnt;
  logic                 edgeSeen;

  always_ff @(posedge sampClk) begin
    if (masterRst) shiftQ <= '0;
    else           shiftQ <= {shiftQ[SYNC_STAGES-1:0], rawClk};
  end

  assign edgeSeen = shiftQ[SYNC_STAGES] ^ shiftQ[SYNC_STAGES-1];

  // idle counter: cleared by reset or a transition, saturates at LIMIT
  always_ff @(posedge sampClk) begin
    if (masterRst || edgeSeen) idleCnt <= '0;
    else if (idleCnt != LIMIT) idleCnt <= idleCnt + 1'b1;
  end

  assign stuck = (idleCnt == LIMIT);

  // R2: a detected transition always withdraws the stuck indication
  a_r2_edge_restarts: assert property (@(posedge sampClk) disable iff (masterRst)
    edgeSeen |=> !stuck);

  // R9: the detector leaves reset counting from zero
  a_r9_restart: assert property (@(posedge sampClk)
    masterRst |=> (idleCnt == '0) || masterRst);
endmodule

// File: rtl/clkswDatapath.sv
module clkswDatapath
  import clkswPkg::*;
#(
  parameter int TIMEOUT     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               sampClk,
  input  logic               masterRst,
  input  logic [NUM_REF-1:0] refClk,
  input  swStrobe_t          strb,
  output logic [NUM_REF-1:0] timeout,
  output logic [NUM_REF-1:0] badFlag,
  output logic               selCur
);
  for (genvar i = 0; i < NUM_REF; i++) begin : g_mon
    clkswMonitor #(
      .TIMEOUT     (TIMEOUT),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_mon (
      .sampClk   (sampClk),
      .masterRst (masterRst),
      .rawClk    (refClk[i]),
      .stuck     (timeout[i])
    );

    // R3: a raised flag holds unless cleared
    a_r3_flag_latched: assert property (@(posedge sampClk) disable iff (masterRst)
      badFlag[i] && !strb.clrBad |=> badFlag[i]);

    // R1: a flag rises only after its detector timed out
    a_r1_flag_needs_timeout: assert property (@(posedge sampClk) disable iff (masterRst)
      $rose(badFlag[i]) |-> $past(timeout[i]));
  end

  // latched failure flags
  always_ff @(posedge sampClk) begin
    if (masterRst || strb.clrBad) badFlag <= '0;
    else                          badFlag <= badFlag | strb.setBad;
  end

  // selection register, written only by control
  always_ff @(posedge sampClk) begin
    if (strb.selLoad) selCur <= strb.selNext;
  end

  // R4: an alarm clear empties both flags at the next edge
  a_r4_alarm_clears: assert property (@(posedge sampClk) disable iff (masterRst)
    strb.clrBad |=> badFlag == '0);
endmodule

// File: rtl/clkswControl.sv
module clkswControl
  import clkswPkg::*;
(
  input  logic               sampClk,
  input  logic               masterRst,
  input  logic               alarmClr,
  input  logic               manOverride,
  input  logic               selPin,
  input  logic [NUM_REF-1:0] timeout,
  input  logic [NUM_REF-1:0] badFlag,
  input  logic               selCur,
  output swStrobe_t          strb
);
  logic curBad;
  logic otherBad;

  assign curBad   = badFlag[selCur];
  assign otherBad = badFlag[!selCur];

  always_comb begin
    strb        = '0;
    strb.setBad = timeout;
    strb.clrBad = alarmClr;
    strb.selNext = selCur;
    if (masterRst || manOverride || alarmClr) begin
      strb.selLoad = 1'b1;
      strb.selNext = selPin;
    end else if (curBad && !otherBad) begin
      strb.selLoad = 1'b1;
      strb.selNext = !selCur;
    end
  end

  // R8: override makes the selection follow the pin
  a_r8_override_follows: assert property (@(posedge sampClk) disable iff (masterRst)
    manOverride |=> selCur == $past(selPin));

  // R5: a failed selection with a healthy alternative flips
  a_r5_switch_away: assert property (@(posedge sampClk) disable iff (masterRst)
    !manOverride && !alarmClr && curBad && !otherBad |=> selCur != $past(selCur));

  // R6: the selection does not move while its own reference is healthy
  a_r6_other_fail_no_switch: assert property (@(posedge sampClk) disable iff (masterRst)
    !manOverride && !alarmClr && !curBad |=> $stable(selCur));

  // R7: both flagged means hold
  a_r7_both_bad_hold: assert property (@(posedge sampClk) disable iff (masterRst)
    !manOverride && !alarmClr && curBad && otherBad |=> $stable(selCur));
endmodule

// File: rtl/clkFailSwitch.sv
module clkFailSwitch
  import clkswPkg::*;
#(
  parameter int TIMEOUT     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic sampClk,
  input  logic masterRst,
  input  logic refClk0,
  input  logic refClk1,
  input  logic alarmClr,
  input  logic manOverride,
  input  logic selPin,
  output logic badFlag0,
  output logic badFlag1,
  output logic clkSelected
);
  swStrobe_t          strb;
  logic [NUM_REF-1:0] timeout;
  logic [NUM_REF-1:0] badFlag;
  logic               selCur;

  clkswDatapath #(
    .TIMEOUT     (TIMEOUT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .sampClk   (sampClk),
    .masterRst (masterRst),
    .refClk    ({refClk1, refClk0}),
    .strb      (strb),
    .timeout   (timeout),
    .badFlag   (badFlag),
    .selCur    (selCur)
  );

  clkswControl u_ctl (
    .sampClk     (sampClk),
    .masterRst   (masterRst),
    .alarmClr    (alarmClr),
    .manOverride (manOverride),
    .selPin      (selPin),
    .timeout     (timeout),
    .badFlag     (badFlag),
    .selCur      (selCur),
    .strb        (strb)
  );

  assign badFlag0    = badFlag[0];
  assign badFlag1    = badFlag[1];
  assign clkSelected = selCur;  // R10: 0 = reference 0, 1 = reference 1
endmodule

// File: tb/clkFailSwitch_bench.sv
module clkFailSwitch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 12;

  logic sampClk = 1'b0;
  logic masterRst = 1'b1;
  logic refClk0 = 1'b0, refClk1 = 1'b0;
  logic alarmClr = 1'b0, manOverride = 1'b0, selPin = 1'b1;
  logic badFlag0, badFlag1, clkSelected;

  // reference generators: ref0 toggles every 4 cycles, ref1 every 5
  logic run0 = 1'b1, run1 = 1'b1, lvl0 = 1'b0, lvl1 = 1'b0;
  int   ph0 = 0, ph1 = 0;
  int   nChecks = 0, nFails = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) sampClk = ~sampClk;

  clkFailSwitch #(.TIMEOUT(TIMEOUT), .SYNC_STAGES(2)) u_clkFailSwitch (
    .sampClk     (sampClk),
    .masterRst   (masterRst),
    .refClk0     (refClk0),
    .refClk1     (refClk1),
    .alarmClr    (alarmClr),
    .manOverride (manOverride),
    .selPin      (selPin),
    .badFlag0    (badFlag0),
    .badFlag1    (badFlag1),
    .clkSelected (clkSelected)
  );

  always @(negedge sampClk) begin
    if (run0) begin
      if (ph0 == 3) begin ph0 <= 0; refClk0 <= ~refClk0; end
      else ph0 <= ph0 + 1;
    end else refClk0 <= lvl0;
    if (run1) begin
      if (ph1 == 4) begin ph1 <= 0; refClk1 <= ~refClk1; end
      else ph1 <= ph1 + 1;
    end else refClk1 <= lvl1;
  end

  // fields: run0 lvl0 run1 lvl1 ovr selPin alarm expBad0 expBad1 expSel
  localparam logic [9:0] VEC [0:11] = '{
    10'b1_0_1_0_0_0_1_0_0_0,  // healthy, alarm loads pin 0      (R4)
    10'b0_0_1_0_0_0_0_1_0_1,  // ref0 stuck low, switch to 1     (R1 R5)
    10'b1_0_1_0_0_0_0_1_0_1,  // ref0 recovers, flag latched     (R3)
    10'b1_0_1_0_0_0_1_0_0_0,  // alarm clears, back to pin 0     (R4)
    10'b1_0_0_1_0_0_0_0_1_0,  // unselected ref1 stuck high      (R6)
    10'b0_1_0_1_0_0_0_1_1_0,  // ref0 stuck high too, hold       (R7)
    10'b0_1_0_1_0_1_1_1_1_1,  // alarm while dead: reflag, pin 1 (R4 R7)
    10'b1_0_1_0_0_1_1_0_0_1,  // all healthy again               (R4 R10)
    10'b0_0_1_0_1_0_0_1_0_0,  // override keeps bad ref0         (R8)
    10'b0_0_1_0_0_0_0_1_0_1,  // override off: auto switch       (R5)
    10'b1_0_1_0_1_1_1_0_0_1,  // override pin 1, clear           (R8)
    10'b1_0_1_0_1_0_0_0_0_0   // override pin 0                  (R8)
  };

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge sampClk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    // R9: master reset with pin 1
    waitCyc(6);
    masterRst = 1'b0;
    check("R9 reset bad0", badFlag0, 1'b0);
    check("R9 reset bad1", badFlag1, 1'b0);
    check("R9 reset sel", clkSelected, 1'b1);
    waitCyc(20);

    for (int s = 0; s < 12; s++) begin
      run0 = VEC[s][9]; lvl0 = VEC[s][8];
      run1 = VEC[s][7]; lvl1 = VEC[s][6];
      manOverride = VEC[s][5]; selPin = VEC[s][4];
      waitCyc(8);
      if (VEC[s][3]) begin alarmClr = 1'b1; waitCyc(1); alarmClr = 1'b0; end
      waitCyc(32);
      check($sformatf("R1/R3/R4 step %0d bad0", s), badFlag0, VEC[s][2]);
      check($sformatf("R6/R7 step %0d bad1", s), badFlag1, VEC[s][1]);
      check($sformatf("R5/R8/R10 step %0d sel", s), clkSelected, VEC[s][0]);
    end

    // R2: short pause on ref1 is not a failure
    manOverride = 1'b0; selPin = 1'b0;
    waitCyc(2);
    run1 = 1'b0; lvl1 = refClk1;
    waitCyc(6);
    run1 = 1'b1;
    waitCyc(30);
    check("R2 short pause bad1", badFlag1, 1'b0);

    // R1: detection window on ref1 stuck low; R6 selection stays on 0
    run1 = 1'b0; lvl1 = 1'b0;
    waitCyc(10);
    check("R1 not early bad1", badFlag1, 1'b0);
    waitCyc(10);
    check("R1 in window bad1", badFlag1, 1'b1);
    check("R6 sel unchanged", clkSelected, 1'b0);

    // R9: master reset mid-run loads pin 1 and clears flags
    selPin = 1'b1; masterRst = 1'b1;
    waitCyc(2);
    masterRst = 1'b0;
    check("R9 mid reset bad1", badFlag1, 1'b0);
    check("R9 mid reset sel", clkSelected, 1'b1);

    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge sampClk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end
endmodule